// File: doc/BRIEF.md
# Banked Register Window with Per-Group Bank Pointers

This block gives a simple synchronous host bus (8-bit address, separate read and write strobes, 8-bit data) access to a set of register banks through a small address window. The 256-byte address space holds two 32-byte windows. Addresses 00h to 1Fh belong to port group A, which covers ports 1 to 8. Addresses 20h to 3Fh belong to port group B, which covers ports 9 to 16. The last byte of each window is that group's bank pointer. The value software writes to the pointer decides which bank the other 31 bytes of that window show.

Each group's pointer can select one of five bank kinds: a primary bank, a secondary bank, an individual-port bank, a BERT bank, or the test bank of one port in the group. Each test bank holds five read/write adjust registers. The primary, secondary, individual-port and BERT banks are modelled here as plain byte storage. To move from one bank to another, software writes a new code to the pointer. The pointer stays visible in every bank, so software can always get back to the primary bank.

Top module: `bwr_window_regs`

## Requirements
- R1: After a synchronous reset, both pointers read 00h, and every storage byte in every bank and every test register reads 00h.
- R2: The group pointer is at window offset 1Fh, which is address 1Fh for group A and 3Fh for group B. It stores any 8-bit value written to it and reads back that value whatever bank is selected.
- R3: Pointer code 00h selects the primary bank, AAh the secondary bank, 01h the individual-port bank and 02h the BERT bank. For each group, each of these banks is a separate 31-byte store at window offsets 00h to 1Eh.
- R4: Pointer codes 04h to 0Bh select the test bank of ports 1 to 8 in group A, or of ports 9 to 16 in group B. Code 04h selects the lowest port of the group. Each test bank has five registers at window offsets 00h to 04h, and the contents are kept while other banks are selected.
- R5: While a test bank is selected, window offsets 05h to 1Eh read 00h, and writes to them change no register.
- R6: With any other pointer code (03h, 0Ch to A9h, ABh to FFh), reads at window offsets 00h to 1Eh return 00h and writes change nothing.
- R7: Address bit 5 selects the group. Writing one group's pointer or banks does not change what the other group shows.
- R8: Addresses 40h to FFh read 00h, and writes to them change no register, including the pointers.
- R9: Read data is registered. It appears after the clock edge that samples the read strobe and holds its value while the read strobe is low. A read and a write to the same location at the same edge return the old contents.
- R10: A write takes effect at the clock edge that samples the write strobe, so a read issued in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Host byte address |
| host_wr | input | 1 | Write strobe, sampled at the rising edge |
| host_rd | input | 1 | Read strobe, sampled at the rising edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |

## Verification
The decoded bank state is never observed directly. The bench sees it only as data that appears in the wrong place, and it shows up as soon as the affected location is read back. A pointer that decodes wrongly sends a write to a different bank. The bench detects this on the first read after switching banks: the bank that should hold the value reads 00h, or a bank that should be untouched returns the value. A wrong group split or a wrong port offset in the test-bank index shows up the same way, as a value that leaks between ports 1 and 9 or between ports 8 and 16. A fault in the read register appears one cycle after the strobe, or while the strobe is idle, as data that does not hold.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int PLAIN_KINDS = 4;

    localparam logic [7:0] CODE_PRIMARY   = 8'h00;
    localparam logic [7:0] CODE_SECONDARY = 8'hAA;
    localparam logic [7:0] CODE_PERPORT   = 8'h01;
    localparam logic [7:0] CODE_BERT      = 8'h02;
    localparam logic [7:0] CODE_TEST_BASE = 8'h04;

    // The first four kinds index the plain stores directly.
    typedef enum logic [2:0] {
        BK_PRIMARY   = 3'd0,
        BK_SECONDARY = 3'd1,
        BK_PERPORT   = 3'd2,
        BK_BERT      = 3'd3,
        BK_TEST      = 3'd4,
        BK_NONE      = 3'd5
    } bank_kind_e;

    typedef struct packed {
        bank_kind_e  kind;
        logic [7:0]  test_sel;
    } bank_sel_t;

    function automatic bank_sel_t decode_code(input logic [7:0] code, input int n_test);
        bank_sel_t s;
        s.kind     = BK_NONE;
        s.test_sel = '0;
        if (code == CODE_PRIMARY)        s.kind = BK_PRIMARY;
        else if (code == CODE_SECONDARY) s.kind = BK_SECONDARY;
        else if (code == CODE_PERPORT)   s.kind = BK_PERPORT;
        else if (code == CODE_BERT)      s.kind = BK_BERT;
        else if (int'(code) >= int'(CODE_TEST_BASE) &&
                 int'(code) <  int'(CODE_TEST_BASE) + n_test) begin
            s.kind     = BK_TEST;
            s.test_sel = code - CODE_TEST_BASE;
        end
        return s;
    endfunction

endpackage

// File: rtl/bwr_ptr_reg.sv
module bwr_ptr_reg
    import bwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ptr
);

    logic [DATA_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst)     ptr_q <= '0;
        else if (we) ptr_q <= wdata;
    end

    assign ptr = ptr_q;

    // R2: the pointer only moves on its own write strobe
    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(ptr_q));

endmodule

// File: rtl/bwr_plain_store.sv
module bwr_plain_store
    import bwr_pkg::*;
#(
    parameter int DEPTH = 31,
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              idx_ok;

    assign idx_ok = (idx < IDX_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && idx_ok) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = idx_ok ? mem[idx] : '0;

    // R3: without a write, the byte at an unchanged index keeps its value
    p_plain_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !we |=> (idx != $past(idx)) || $stable(rdata));

endmodule

// File: rtl/bwr_test_regs.sv
module bwr_test_regs
    import bwr_pkg::*;
#(
    parameter int PORTS  = 16,
    parameter int REGS   = 5,
    parameter int PORT_W = 4,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PORT_W-1:0] port,
    input  logic [REG_W-1:0]  regsel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] adj [PORTS][REGS];
    logic              reg_ok;

    assign reg_ok = (regsel < REG_W'(REGS)) && (int'(port) < PORTS);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < PORTS; p++)
                for (int r = 0; r < REGS; r++)
                    adj[p][r] <= '0;
        end else if (we && reg_ok) begin
            adj[port][regsel] <= wdata;
        end
    end

    assign rdata = reg_ok ? adj[port][regsel] : '0;

    // R5: the window decode never strobes a register beyond the bank
    p_test_idx_r5: assert property (@(posedge clk) disable iff (rst)
        we |-> (regsel < REG_W'(REGS)));

endmodule

// File: rtl/bwr_window_regs.sv
module bwr_window_regs
    import bwr_pkg::*;
#(
    parameter int GROUPS          = 2,
    parameter int PORTS_PER_GROUP = 8,
    parameter int TEST_REGS       = 5,
    parameter int WIN_BITS        = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);

    localparam int WIN_SPAN    = 1 << WIN_BITS;
    localparam int PTR_OFF     = WIN_SPAN - 1;
    localparam int PLAIN_DEPTH = WIN_SPAN - 1;
    localparam int GRP_BITS    = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int N_PORTS     = GROUPS * PORTS_PER_GROUP;
    localparam int PORT_W      = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
    localparam int N_WE        = GROUPS * PLAIN_KINDS;

    // ---- address decode ----
    logic [WIN_BITS-1:0] off;
    logic [GRP_BITS-1:0] grp;
    logic                in_win, is_ptr, is_data;

    assign off     = host_addr[WIN_BITS-1:0];
    assign grp     = host_addr[WIN_BITS +: GRP_BITS];
    assign in_win  = ((host_addr >> (WIN_BITS + GRP_BITS)) == '0) && (int'(grp) < GROUPS);
    assign is_ptr  = in_win && (off == WIN_BITS'(PTR_OFF));
    assign is_data = in_win && !is_ptr;

    // ---- pointers ----
    logic [DATA_W-1:0] ptr_val [GROUPS];
    logic [GROUPS-1:0] ptr_we;

    for (genvar g = 0; g < GROUPS; g++) begin : g_ptr
        assign ptr_we[g] = host_wr && is_ptr && (int'(grp) == g);
        bwr_ptr_reg u_ptr (
            .clk   (clk),
            .rst   (rst),
            .we    (ptr_we[g]),
            .wdata (host_wdata),
            .ptr   (ptr_val[g])
        );
    end

    bank_sel_t cur_sel;
    assign cur_sel = decode_code(ptr_val[grp], PORTS_PER_GROUP);

    // ---- plain banks: one store per group and kind ----
    logic [DATA_W-1:0] plain_rd [GROUPS][PLAIN_KINDS];
    logic [N_WE-1:0]   plain_we;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar k = 0; k < PLAIN_KINDS; k++) begin : g_kind
            assign plain_we[g*PLAIN_KINDS + k] = host_wr && is_data &&
                (int'(grp) == g) && (cur_sel.kind == bank_kind_e'(k));
            bwr_plain_store #(
                .DEPTH (PLAIN_DEPTH),
                .IDX_W (WIN_BITS)
            ) u_store (
                .clk   (clk),
                .rst   (rst),
                .we    (plain_we[g*PLAIN_KINDS + k]),
                .idx   (off),
                .wdata (host_wdata),
                .rdata (plain_rd[g][k])
            );
        end
    end

    // ---- per-port test banks ----
    logic [PORT_W-1:0] test_port;
    logic              test_we;
    logic [DATA_W-1:0] test_rd;

    assign test_port = PORT_W'(grp) * PORT_W'(PORTS_PER_GROUP) + PORT_W'(cur_sel.test_sel);
    assign test_we   = host_wr && is_data && (cur_sel.kind == BK_TEST) &&
                       (off < WIN_BITS'(TEST_REGS));

    bwr_test_regs #(
        .PORTS  (N_PORTS),
        .REGS   (TEST_REGS),
        .PORT_W (PORT_W),
        .REG_W  (WIN_BITS)
    ) u_test (
        .clk    (clk),
        .rst    (rst),
        .we     (test_we),
        .port   (test_port),
        .regsel (off),
        .wdata  (host_wdata),
        .rdata  (test_rd)
    );

    // ---- read path ----
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (is_ptr) begin
            rd_mux = ptr_val[grp];
        end else if (is_data) begin
            case (cur_sel.kind)
                BK_TEST: rd_mux = test_rd;
                BK_NONE: rd_mux = '0;
                default: rd_mux = plain_rd[grp][cur_sel.kind[1:0]];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    // R3: at most one storage element is strobed per access
    p_one_target_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({plain_we, test_we, ptr_we}));

    // R8: reads outside the two windows return zero
    p_outside_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !in_win) |=> (host_rdata == '0));

    // R6: reads through an undefined pointer code return zero
    p_undef_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (host_rd && is_data && cur_sel.kind == BK_NONE) |=> (host_rdata == '0));

    // R9: read data holds while the read strobe is idle
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata));

endmodule

// File: tb/tb_bwr_window_regs.sv
`timescale 1ns/1ps
module tb_bwr_window_regs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bwr_window_regs dut (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr8(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd8(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic expect_rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd8(a, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset();
        expect_rd("R1 ptr A", 8'h1F, 8'h00);
        expect_rd("R1 ptr B", 8'h3F, 8'h00);
        expect_rd("R1 primary A", 8'h03, 8'h00);
        expect_rd("R1 primary B", 8'h2E, 8'h00);
    endtask

    task automatic t_pointer();
        wr8(8'h1F, 8'h5A);
        expect_rd("R2 ptr A value", 8'h1F, 8'h5A);
        wr8(8'h3F, 8'hC3);
        expect_rd("R7 ptr A after B write", 8'h1F, 8'h5A);
        expect_rd("R2 ptr B value", 8'h3F, 8'hC3);
        wr8(8'h1F, 8'h00);
        wr8(8'h3F, 8'h00);
    endtask

    task automatic t_plain_banks();
        wr8(8'h1F, 8'h00); wr8(8'h03, 8'h11); wr8(8'h1E, 8'h9E);
        wr8(8'h1F, 8'hAA); wr8(8'h03, 8'h22);
        wr8(8'h1F, 8'h01); wr8(8'h03, 8'h33);
        wr8(8'h1F, 8'h02); wr8(8'h03, 8'h44);
        wr8(8'h1F, 8'h00);
        expect_rd("R3 primary", 8'h03, 8'h11);
        expect_rd("R3 primary top offset", 8'h1E, 8'h9E);
        wr8(8'h1F, 8'hAA); expect_rd("R3 secondary", 8'h03, 8'h22);
        wr8(8'h1F, 8'h01); expect_rd("R3 individual", 8'h03, 8'h33);
        wr8(8'h1F, 8'h02); expect_rd("R3 BERT", 8'h03, 8'h44);
        wr8(8'h1F, 8'h00);
    endtask

    task automatic t_groups();
        wr8(8'h23, 8'h77);
        expect_rd("R7 group B primary", 8'h23, 8'h77);
        expect_rd("R7 group A unchanged", 8'h03, 8'h11);
        wr8(8'h3F, 8'hAA);
        expect_rd("R7 group B secondary empty", 8'h23, 8'h00);
        expect_rd("R7 group A still primary", 8'h03, 8'h11);
        wr8(8'h3F, 8'h00);
    endtask

    task automatic t_test_banks();
        wr8(8'h1F, 8'h04); wr8(8'h00, 8'hA1);
        wr8(8'h1F, 8'h0B); wr8(8'h04, 8'hB8);
        wr8(8'h3F, 8'h04); wr8(8'h22, 8'hC2);
        wr8(8'h3F, 8'h0B); wr8(8'h24, 8'hD8);
        expect_rd("R2 ptr visible in test bank", 8'h1F, 8'h0B);
        expect_rd("R4 port8 reg4", 8'h04, 8'hB8);
        expect_rd("R4 port8 reg0", 8'h00, 8'h00);
        expect_rd("R4 port16 reg4", 8'h24, 8'hD8);
        wr8(8'h1F, 8'h04);
        expect_rd("R4 port1 reg0", 8'h00, 8'hA1);
        expect_rd("R4 port1 reg4", 8'h04, 8'h00);
        wr8(8'h3F, 8'h04);
        expect_rd("R4 port9 reg2", 8'h22, 8'hC2);
        expect_rd("R4 port9 reg0 apart from port1", 8'h20, 8'h00);
    endtask

    task automatic t_test_high();
        wr8(8'h1F, 8'h04);
        wr8(8'h05, 8'hEE);
        wr8(8'h1E, 8'hEF);
        expect_rd("R5 offset 05h", 8'h05, 8'h00);
        expect_rd("R5 offset 1Eh", 8'h1E, 8'h00);
        expect_rd("R5 port1 reg0 intact", 8'h00, 8'hA1);
        wr8(8'h1F, 8'h00);
        expect_rd("R5 primary 05h untouched", 8'h05, 8'h00);
        expect_rd("R5 primary 1Eh untouched", 8'h1E, 8'h9E);
    endtask

    task automatic t_reserved();
        wr8(8'h1F, 8'h03);
        expect_rd("R6 code 03h read", 8'h03, 8'h00);
        wr8(8'h03, 8'hFF);
        wr8(8'h1F, 8'h0C); wr8(8'h00, 8'hFE);
        expect_rd("R6 code 0Ch read", 8'h00, 8'h00);
        wr8(8'h1F, 8'hAB); wr8(8'h03, 8'hFD);
        expect_rd("R6 code ABh read", 8'h03, 8'h00);
        wr8(8'h1F, 8'h00);
        expect_rd("R6 primary intact", 8'h03, 8'h11);
        wr8(8'h1F, 8'h04);
        expect_rd("R6 port1 reg0 intact", 8'h00, 8'hA1);
        wr8(8'h1F, 8'h00);
    endtask

    task automatic t_outside();
        wr8(8'h43, 8'h55);
        wr8(8'hFF, 8'h66);
        wr8(8'hDF, 8'h67);
        expect_rd("R8 read 43h", 8'h43, 8'h00);
        expect_rd("R8 read FFh", 8'hFF, 8'h00);
        expect_rd("R8 primary 03h intact", 8'h03, 8'h11);
        expect_rd("R8 ptr A intact", 8'h1F, 8'h00);
        expect_rd("R8 ptr B intact", 8'h3F, 8'h04);
    endtask

    task automatic t_timing();
        logic [7:0] v;
        rd8(8'h03, v);
        check("R9 read value", v, 8'h11);
        @(negedge clk); host_addr = 8'h1E;
        @(negedge clk); @(negedge clk);
        check("R9 hold while idle", host_rdata, 8'h11);
        // read and write at the same edge
        @(negedge clk);
        host_addr = 8'h03; host_wdata = 8'h12; host_wr = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        check("R9 same-edge read returns old", host_rdata, 8'h11);
        expect_rd("R10 next-cycle read sees write", 8'h03, 8'h12);
        // write immediately followed by read of a fresh location
        @(negedge clk);
        host_addr = 8'h07; host_wdata = 8'h3C; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check("R10 back-to-back write then read", host_rdata, 8'h3C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pointer();
        t_plain_banks();
        t_groups();
        t_test_banks();
        t_test_high();
        t_reserved();
        t_outside();
        t_timing();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got 00 expected 01");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule